// File: doc/BRIEF.md
# Stall-Cause Tracker

This block records why a cache is stalled. It keeps two independent cause masks, one for the demand access path and one for the snoop path. Each mask holds one bit per stall cause. Callers raise a cause on either path with a set strobe and a cause index. A single clear strobe drops a cause from both masks at once. Each path's blocked output is high while its mask holds any cause, and these outputs steer the CPU-facing and memory-facing ports.

For the access path only, the block also keeps statistics. When the path goes from idle to stalled, the block bumps an event counter for the cause that started the stall and latches a free-running cycle count. When a clear empties the access mask, the cycles elapsed since that latch are added to a per-cause cycle counter, charged to the cause whose clear ended the stall. All counters saturate instead of wrapping.

Top module: `stall_tracker`

## Requirements
- R1: A set for cause c (encodings: 0 no free miss registers, 1 no free targets, 2 no free writeback buffers, 3 coherence) sets bit c of that path's mask, visible on the mask output the cycle after the strobe.
- R2: The access mask and the snoop mask are independent. A set on one path leaves the other path's mask and blocked output unchanged.
- R3: A set for a cause whose bit is already present changes neither the mask nor any counter.
- R4: `cpu_blocked` is high exactly when the access mask is nonzero. `mem_blocked` is high exactly when the snoop mask is nonzero.
- R5: An access-path set that arrives while the access mask is empty adds one to the event counter of that cause and latches the current cycle count. An access-path set while the mask is nonempty adds nothing.
- R6: A clear for cause c removes bit c from both masks wherever it is present. A clear for a cause that is absent leaves the masks and counters unchanged.
- R7: A clear that empties the access mask adds, to the cycle counter of the cleared cause, the number of clock edges from the edge that latched the start to the edge that took the clear. The same clear drops `cpu_blocked`.
- R8: The snoop path keeps no statistics. Setting and clearing snoop causes changes no counter, and a clear that empties the snoop mask drops `mem_blocked`.
- R9: When a set and a clear arrive in the same cycle, the clear is applied first and the set second. This holds for the masks and for the statistics.
- R10: Every event and cycle counter saturates at its all-ones value.
- R11: Reset clears both masks and all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_set_vld | input | 1 | Raise a cause on the access path |
| acc_set_cause | input | CAUSE_W | Cause index for the access-path set |
| snp_set_vld | input | 1 | Raise a cause on the snoop path |
| snp_set_cause | input | CAUSE_W | Cause index for the snoop-path set |
| clr_vld | input | 1 | Drop a cause from both paths |
| clr_cause | input | CAUSE_W | Cause index for the clear |
| cpu_blocked | output | 1 | Access path stalled (mask nonzero) |
| mem_blocked | output | 1 | Snoop path stalled (mask nonzero) |
| acc_mask | output | NUM_CAUSES | Access-path cause mask, bit c = cause c |
| snp_mask | output | NUM_CAUSES | Snoop-path cause mask, bit c = cause c |
| evt_cnt_flat | output | NUM_CAUSES*CNT_W | Stall-start counters, cause c at bits [c*CNT_W +: CNT_W] |
| cyc_cnt_flat | output | NUM_CAUSES*CNT_W | Stalled-cycle counters, same packing |

## Verification
The tests drive a single cause through set and clear to confirm that it starts and ends an episode. They stack several causes so that only the first set counts and only the last clear charges cycles, and they repeat sets of a cause already present to show those sets change nothing. Snoop-only traffic, plus a clear shared by both paths, shows that the two masks stay separate and that the snoop path does no accounting. Simultaneous set and clear of the same cause, on a stalled path and on an idle one, fix the clear-then-set order. Long and repeated episodes on a narrow counter build push both kinds of counter into saturation.

// File: rtl/stall_tracker_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and cause encoding for the stall-cause tracker.
// Assumes cause indices are small unsigned integers used as mask bit numbers.
package stall_tracker_pkg;

    // Default number of tracked stall causes.
    localparam int unsigned STALL_CAUSES_DEF = 4;

    // Encoding of the stall causes; the value is the mask bit position.
    typedef enum logic [1:0] {
        STALL_NO_MISS_REG = 2'd0,
        STALL_NO_TARGET   = 2'd1,
        STALL_NO_WB_BUF   = 2'd2,
        STALL_COHERENCE   = 2'd3
    } stall_cause_e;

endpackage

// File: rtl/stall_mask_path.sv
`timescale 1ns/1ps
// Module: one path's cause mask.
// Applies a clear and then a set each cycle. Reports whether the mask is
// nonzero, whether a set opened a new stall episode (the mask was empty
// after the clear), and whether a clear closed an episode (it removed a
// present bit and left the mask empty).
// Assumes cause indices at or above N are out of range and select no bit.
module stall_mask_path #(
    parameter int unsigned N  = 4,
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_vld,
    input  logic [CW-1:0] set_cause,
    input  logic          clr_vld,
    input  logic [CW-1:0] clr_cause,
    output logic [N-1:0]  mask_q,
    output logic          blocked,
    output logic          episode_begin,
    output logic          episode_end
);

    logic [N-1:0] set_bit;
    logic [N-1:0] clr_bit;
    logic [N-1:0] mask_mid;
    logic [N-1:0] mask_nxt;

    // Decode the strobes into one-hot bits and build the next mask, clear first.
    always_comb begin
        set_bit  = set_vld ? (N'(1) << set_cause) : '0;
        clr_bit  = clr_vld ? (N'(1) << clr_cause) : '0;
        mask_mid = mask_q & ~clr_bit;
        mask_nxt = mask_mid | set_bit;
    end

    // Flag the empty-to-stalled and stalled-to-empty transitions.
    always_comb begin
        episode_begin = set_vld && (mask_mid == '0);
        episode_end   = ((mask_q & clr_bit) != '0) && (mask_mid == '0);
    end

    // Hold the mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_nxt;
        end
    end

    // The path is stalled while any cause bit is present.
    assign blocked = |mask_q;

endmodule

// File: rtl/stall_cycle_timer.sv
`timescale 1ns/1ps
// Module: free-running cycle count used as the time base for stall spans.
// Wraps silently; spans are taken as modular differences, so a span is
// exact as long as it is shorter than 2**W cycles.
module stall_cycle_timer #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] now_q
);

    // Advance the time base by one every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q <= '0;
        end else begin
            now_q <= now_q + W'(1);
        end
    end

endmodule

// File: rtl/stall_sat_counter.sv
`timescale 1ns/1ps
// Module: saturating accumulator.
// Adds inc_amt when inc_vld is high; a sum past the top sticks at all ones.
// Assumes the amount is unsigned and no wider than the counter.
module stall_sat_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_vld,
    input  logic [W-1:0] inc_amt,
    output logic [W-1:0] cnt_q
);

    logic [W:0]   sum_wide;
    logic [W-1:0] cnt_nxt;

    // Form the sum with a carry bit and clamp on carry-out.
    always_comb begin
        sum_wide = {1'b0, cnt_q} + {1'b0, inc_amt};
        cnt_nxt  = sum_wide[W] ? {W{1'b1}} : sum_wide[W-1:0];
    end

    // Register the accumulated value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc_vld) begin
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/stall_tracker.sv
`timescale 1ns/1ps
// Module: stall-cause tracker top.
// Keeps an access-path mask and a snoop-path mask of stall causes and drives
// one blocked output per path. On the access path only, it counts stall
// episodes per starting cause and charges the span of each episode to the
// cause whose clear ended it. All counters saturate.
// Assumes at most one set per path and one shared clear per cycle.
module stall_tracker
    import stall_tracker_pkg::*;
#(
    parameter int unsigned NUM_CAUSES = STALL_CAUSES_DEF,
    parameter int unsigned CNT_W      = 32,
    localparam int unsigned CAUSE_W   = (NUM_CAUSES > 1) ? $clog2(NUM_CAUSES) : 1,
    localparam int unsigned FLAT_W    = NUM_CAUSES * CNT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_set_vld,
    input  logic [CAUSE_W-1:0]    acc_set_cause,
    input  logic                  snp_set_vld,
    input  logic [CAUSE_W-1:0]    snp_set_cause,
    input  logic                  clr_vld,
    input  logic [CAUSE_W-1:0]    clr_cause,
    output logic                  cpu_blocked,
    output logic                  mem_blocked,
    output logic [NUM_CAUSES-1:0] acc_mask,
    output logic [NUM_CAUSES-1:0] snp_mask,
    output logic [FLAT_W-1:0]     evt_cnt_flat,
    output logic [FLAT_W-1:0]     cyc_cnt_flat
);

    logic             acc_begin;
    logic             acc_end;
    logic             snp_begin;
    logic             snp_end;
    logic             snp_unused;
    logic [CNT_W-1:0] now_cyc;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] span;

    stall_mask_path #(.N(NUM_CAUSES), .CW(CAUSE_W)) u_acc_path (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_vld       (acc_set_vld),
        .set_cause     (acc_set_cause),
        .clr_vld       (clr_vld),
        .clr_cause     (clr_cause),
        .mask_q        (acc_mask),
        .blocked       (cpu_blocked),
        .episode_begin (acc_begin),
        .episode_end   (acc_end)
    );

    stall_mask_path #(.N(NUM_CAUSES), .CW(CAUSE_W)) u_snp_path (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_vld       (snp_set_vld),
        .set_cause     (snp_set_cause),
        .clr_vld       (clr_vld),
        .clr_cause     (clr_cause),
        .mask_q        (snp_mask),
        .blocked       (mem_blocked),
        .episode_begin (snp_begin),
        .episode_end   (snp_end)
    );

    // The snoop path does no accounting; its transition flags go nowhere.
    assign snp_unused = snp_begin ^ snp_end;

    stall_cycle_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .now_q (now_cyc)
    );

    // Latch the time base when the access path opens an episode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (acc_begin) begin
            start_q <= now_cyc;
        end
    end

    // Span of the episode being closed, in clock edges.
    assign span = now_cyc - start_q;

    // One event counter and one cycle counter per cause.
    for (genvar gi = 0; gi < NUM_CAUSES; gi++) begin : g_cause
        logic evt_hit;
        logic cyc_hit;

        // Select this cause for the episode start and episode end.
        always_comb begin
            evt_hit = acc_begin && (acc_set_cause == CAUSE_W'(gi));
            cyc_hit = acc_end   && (clr_cause     == CAUSE_W'(gi));
        end

        stall_sat_counter #(.W(CNT_W)) u_evt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_vld (evt_hit),
            .inc_amt (CNT_W'(1)),
            .cnt_q   (evt_cnt_flat[gi*CNT_W +: CNT_W])
        );

        stall_sat_counter #(.W(CNT_W)) u_cyc (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_vld (cyc_hit),
            .inc_amt (span),
            .cnt_q   (cyc_cnt_flat[gi*CNT_W +: CNT_W])
        );
    end

endmodule

// File: rtl/stall_tracker_chk.sv
`timescale 1ns/1ps
// Module: property checker for the stall-cause tracker, bound to the top.
// Observes ports only.
module stall_tracker_chk #(
    parameter int unsigned NUM_CAUSES = 4,
    parameter int unsigned CNT_W      = 32,
    localparam int unsigned CAUSE_W   = (NUM_CAUSES > 1) ? $clog2(NUM_CAUSES) : 1,
    localparam int unsigned FLAT_W    = NUM_CAUSES * CNT_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  acc_set_vld,
    input logic [CAUSE_W-1:0]    acc_set_cause,
    input logic                  snp_set_vld,
    input logic [CAUSE_W-1:0]    snp_set_cause,
    input logic                  clr_vld,
    input logic [CAUSE_W-1:0]    clr_cause,
    input logic                  cpu_blocked,
    input logic                  mem_blocked,
    input logic [NUM_CAUSES-1:0] acc_mask,
    input logic [NUM_CAUSES-1:0] snp_mask,
    input logic [FLAT_W-1:0]     evt_cnt_flat,
    input logic [FLAT_W-1:0]     cyc_cnt_flat
);

    // R1: an in-range access set shows its bit on the next cycle.
    p_set_shows_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_set_vld && (acc_set_cause < NUM_CAUSES)) |=> acc_mask[$past(acc_set_cause)]);

    // R2: the snoop mask holds when it has no set and no clear.
    p_snp_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!snp_set_vld && !clr_vld) |=> $stable(snp_mask) && $stable(mem_blocked));

    // R3: the access mask holds when it has no set and no clear.
    p_acc_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_set_vld && !clr_vld) |=> $stable(acc_mask) && $stable(cpu_blocked));

    // R6: a clear not re-set on the same path leaves the bit absent on both paths.
    p_clr_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && (clr_cause < NUM_CAUSES) && !(acc_set_vld && acc_set_cause == clr_cause))
        |=> !acc_mask[$past(clr_cause)]);

    p_clr_snp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && (clr_cause < NUM_CAUSES) && !(snp_set_vld && snp_set_cause == clr_cause))
        |=> !snp_mask[$past(clr_cause)]);

    // R7: cycle counters move only on a clear.
    p_cyc_needs_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_vld |=> $stable(cyc_cnt_flat));

    // R10: saturating counters never go down.
    for (genvar gi = 0; gi < NUM_CAUSES; gi++) begin : g_mono
        p_evt_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
            evt_cnt_flat[gi*CNT_W +: CNT_W] >= $past(evt_cnt_flat[gi*CNT_W +: CNT_W]));
        p_cyc_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
            cyc_cnt_flat[gi*CNT_W +: CNT_W] >= $past(cyc_cnt_flat[gi*CNT_W +: CNT_W]));
    end

endmodule

bind stall_tracker stall_tracker_chk #(
    .NUM_CAUSES (NUM_CAUSES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_set_vld   (acc_set_vld),
    .acc_set_cause (acc_set_cause),
    .snp_set_vld   (snp_set_vld),
    .snp_set_cause (snp_set_cause),
    .clr_vld       (clr_vld),
    .clr_cause     (clr_cause),
    .cpu_blocked   (cpu_blocked),
    .mem_blocked   (mem_blocked),
    .acc_mask      (acc_mask),
    .snp_mask      (snp_mask),
    .evt_cnt_flat  (evt_cnt_flat),
    .cyc_cnt_flat  (cyc_cnt_flat)
);

// File: tb/tb_stall_tracker.sv
`timescale 1ns/1ps
// Directed bench for the stall-cause tracker; one task per scenario.
// Counters are built 8 bits wide so saturation is reachable.
module tb_stall_tracker;

    localparam int N  = 4;
    localparam int W  = 8;
    localparam int CW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_set_vld = 1'b0;
    logic [CW-1:0]   acc_set_cause = '0;
    logic            snp_set_vld = 1'b0;
    logic [CW-1:0]   snp_set_cause = '0;
    logic            clr_vld = 1'b0;
    logic [CW-1:0]   clr_cause = '0;
    logic            cpu_blocked;
    logic            mem_blocked;
    logic [N-1:0]    acc_mask;
    logic [N-1:0]    snp_mask;
    logic [N*W-1:0]  evt_cnt_flat;
    logic [N*W-1:0]  cyc_cnt_flat;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    stall_tracker #(.NUM_CAUSES(N), .CNT_W(W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_set_vld   (acc_set_vld),
        .acc_set_cause (acc_set_cause),
        .snp_set_vld   (snp_set_vld),
        .snp_set_cause (snp_set_cause),
        .clr_vld       (clr_vld),
        .clr_cause     (clr_cause),
        .cpu_blocked   (cpu_blocked),
        .mem_blocked   (mem_blocked),
        .acc_mask      (acc_mask),
        .snp_mask      (snp_mask),
        .evt_cnt_flat  (evt_cnt_flat),
        .cyc_cnt_flat  (cyc_cnt_flat)
    );

    function automatic int evt(input int c);
        return int'(evt_cnt_flat[c*W +: W]);
    endfunction

    function automatic int cyc(input int c);
        return int'(cyc_cnt_flat[c*W +: W]);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle of strobes starting at a falling edge; returns at the next one.
    task automatic pulse(input logic as, input int ac, input logic ss, input int sc,
                         input logic cl, input int cc);
        acc_set_vld = as; acc_set_cause = CW'(ac);
        snp_set_vld = ss; snp_set_cause = CW'(sc);
        clr_vld = cl;     clr_cause = CW'(cc);
        @(negedge clk);
        acc_set_vld = 1'b0; snp_set_vld = 1'b0; clr_vld = 1'b0;
    endtask

    task automatic set_acc(input int c); pulse(1'b1, c, 1'b0, 0, 1'b0, 0); endtask
    task automatic set_snp(input int c); pulse(1'b0, 0, 1'b1, c, 1'b0, 0); endtask
    task automatic clear(input int c);   pulse(1'b0, 0, 1'b0, 0, 1'b1, c); endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    task automatic check_all_clear(input string tag);
        chk("R11", {tag, " acc_mask"}, int'(acc_mask), 0);
        chk("R11", {tag, " snp_mask"}, int'(snp_mask), 0);
        chk("R11", {tag, " cpu_blocked"}, int'(cpu_blocked), 0);
        chk("R11", {tag, " mem_blocked"}, int'(mem_blocked), 0);
        for (int c = 0; c < N; c++) begin
            chk("R11", {tag, " evt"}, evt(c), 0);
            chk("R11", {tag, " cyc"}, cyc(c), 0);
        end
    endtask

    // R1 R2 R4 R5 R7: one cause, one episode.
    task automatic t_single();
        do_reset();
        set_acc(2);
        chk("R1", "mask after set 2", int'(acc_mask), 4);
        chk("R4", "cpu_blocked", int'(cpu_blocked), 1);
        chk("R2", "snp_mask untouched", int'(snp_mask), 0);
        chk("R2", "mem_blocked untouched", int'(mem_blocked), 0);
        chk("R5", "evt[2]", evt(2), 1);
        idle(5);
        clear(2);
        chk("R7", "cyc[2] span", cyc(2), 6);
        chk("R7", "cpu_blocked dropped", int'(cpu_blocked), 0);
        chk("R4", "acc_mask empty", int'(acc_mask), 0);
    endtask

    // R3 R5 R7: stacked causes, only first set counts, last clear charges.
    task automatic t_stacked();
        do_reset();
        set_acc(1);
        set_acc(1);
        chk("R3", "mask after repeat", int'(acc_mask), 2);
        chk("R3", "evt[1] after repeat", evt(1), 1);
        set_acc(3);
        chk("R5", "evt[3] on busy path", evt(3), 0);
        chk("R1", "mask 1 and 3", int'(acc_mask), 10);
        clear(1);
        chk("R6", "mask after clear 1", int'(acc_mask), 8);
        chk("R7", "cyc[1] not charged", cyc(1), 0);
        chk("R4", "still blocked", int'(cpu_blocked), 1);
        idle(2);
        clear(3);
        chk("R7", "cyc[3] full span", cyc(3), 6);
        chk("R7", "cpu_blocked dropped", int'(cpu_blocked), 0);
    endtask

    // R2 R6 R8: snoop path has no statistics; clear hits both masks.
    task automatic t_snoop();
        do_reset();
        set_snp(0);
        chk("R8", "snp_mask", int'(snp_mask), 1);
        chk("R4", "mem_blocked", int'(mem_blocked), 1);
        chk("R2", "cpu_blocked", int'(cpu_blocked), 0);
        chk("R8", "evt[0] after snoop set", evt(0), 0);
        idle(3);
        clear(0);
        chk("R8", "mem_blocked dropped", int'(mem_blocked), 0);
        chk("R8", "cyc[0] after snoop clear", cyc(0), 0);
        set_acc(2);
        set_snp(2);
        clear(2);
        chk("R6", "acc bit removed", int'(acc_mask), 0);
        chk("R6", "snp bit removed", int'(snp_mask), 0);
        chk("R7", "cyc[2] span 2", cyc(2), 2);
        set_acc(1);
        clear(0);
        chk("R6", "absent clear keeps mask", int'(acc_mask), 2);
        chk("R6", "absent clear cyc[0]", cyc(0), 0);
        chk("R6", "absent clear blocked", int'(cpu_blocked), 1);
    endtask

    // R9: same-cycle clear and set.
    task automatic t_same_cycle();
        do_reset();
        set_acc(1);
        pulse(1'b1, 1, 1'b0, 0, 1'b1, 1);
        chk("R9", "mask after clr+set 1", int'(acc_mask), 2);
        chk("R9", "evt[1] new episode", evt(1), 2);
        chk("R9", "cyc[1] first span", cyc(1), 1);
        clear(1);
        chk("R9", "cyc[1] second span", cyc(1), 2);
        pulse(1'b1, 2, 1'b0, 0, 1'b1, 2);
        chk("R9", "idle clr+set 2 mask", int'(acc_mask), 4);
        chk("R9", "idle clr+set 2 evt", evt(2), 1);
        chk("R9", "idle clr+set 2 cyc", cyc(2), 0);
    endtask

    // R10 R11: saturation, then reset from a busy state.
    task automatic t_saturate();
        do_reset();
        for (int i = 0; i < 260; i++) begin
            set_acc(0);
            clear(0);
        end
        chk("R10", "evt[0] saturated", evt(0), 255);
        chk("R10", "cyc[0] saturated", cyc(0), 255);
        set_acc(3);
        idle(199);
        clear(3);
        chk("R7", "cyc[3] long span", cyc(3), 200);
        set_acc(3);
        idle(99);
        clear(3);
        chk("R10", "cyc[3] saturated", cyc(3), 255);
        set_acc(1);
        set_snp(2);
        do_reset();
        check_all_clear("after busy reset");
    endtask

    initial begin : watchdog
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        idle(2);
        rst_n = 1'b1;
        check_all_clear("initial reset");
        t_single();
        t_stacked();
        t_snoop();
        t_same_cycle();
        t_saturate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule